// File: doc/BRIEF.md
# DMA channel error capture unit

This block sits beside the channel sequencer of a multi-channel DMA engine and is the single place where transfer faults are recorded. It accepts configuration-error events from the transfer datapath (several reporting ports, each carrying a channel number and an error kind), pulses from a priority-configuration checker, and bus faults seen by the sequencer on read or write beats. For every recorded error it sets a sticky flag for the channel and rewrites a 32-bit status word that describes the most recent error.

Bus faults are not always handled at once. A fault on the final read beat before the write half of a burst lets that write complete with the data already captured. A fault on the final write beat before the next read half lets that read complete. In both cases the unit asks the sequencer to finish the pending half, then issues the abort and logs the error. A fault on any other beat aborts on the next cycle. The unit never touches a channel's enable or completion state, so a channel that faults again after its flag is cleared is recorded again. Software-side access is a read of the flag vector and the status word, a write-one-to-clear of the flags, and a clear-by-channel-number port.

Top module: `dma_err_capture`

## Requirements
- R1: A valid configuration-error event on any reporting port sets the flag of its channel in `err_flags`, visible the cycle after the event is presented.
- R2: `err_status[31]` equals the OR of all channel flags. It falls in the same cycle the last flag clears. Clearing flags leaves the priority, channel and kind fields unchanged.
- R3: Status layout, with bit 31 as the most significant bit: [31] valid, [30:16] zero, [15] group-priority error, [14] channel-priority error, [13:8] channel number, [7:0] one-hot kind. Kind codes 0..7 are source address, source offset, destination address, destination offset, transfer-count configuration, scatter/gather, source bus, destination bus, and kind k sets bit 7-k.
- R4: If several channel errors are recorded in one cycle, the status takes the lowest channel number. On equal channel numbers, port 0 wins over port 1, and datapath ports win over the bus-abort path. Every reported channel's flag is set.
- R5: A priority error with no channel error in the same cycle sets [15] and/or [14] as reported, clears [7:0], keeps [13:8], and changes no channel flag.
- R6: `clr_w1c_vld` clears every flag whose bit is 1 in `clr_w1c_mask`, and `clr_chan_vld` clears the flag of `clr_chan`. If a flag is set and cleared in the same cycle, the set wins.
- R7: A bus fault with `bus_flt_last`=0 gives `abort_vld` with `abort_chan` on the next cycle. The following cycle logs it as source-bus kind (read, `bus_flt_wr`=0) or destination-bus kind (write, `bus_flt_wr`=1).
- R8: A bus fault with `bus_flt_last`=1 raises `finish_phase` from the next cycle and holds it, with no abort and no flag, until `phase_done`. The cycle after `phase_done`, `finish_phase` is low and `abort_vld` pulses for that channel, and the error is logged one cycle later with the kind rule of R7.
- R9: Bus faults presented while `finish_phase` is high are ignored: no abort and no flag result from them.
- R10: A channel error in the same cycle as a priority error is the recorded error: [15] and [14] read 0.
- R11: A channel that errors again after its flag was cleared has its flag set and the status rewritten again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_err_vld | input | NUM_SRC | Per-port configuration-error valid |
| cfg_err_chan | input | NUM_SRC x CHW | Per-port channel number |
| cfg_err_kind | input | NUM_SRC x 3 | Per-port error kind code (R3) |
| grp_prio_err | input | 1 | Group priorities not unique |
| ch_prio_err | input | 1 | Channel priorities within a group not unique |
| bus_flt_vld | input | 1 | Bus fault seen on a beat |
| bus_flt_wr | input | 1 | 1 = write beat, 0 = read beat |
| bus_flt_last | input | 1 | Faulting beat was the last of its half |
| bus_flt_chan | input | CHW | Channel of the faulting beat |
| phase_done | input | 1 | Sequencer finished the pending half |
| finish_phase | output | 1 | Sequencer must finish the pending half before abort |
| abort_vld | output | 1 | Terminate the channel now (one-cycle pulse) |
| abort_chan | output | CHW | Channel to terminate |
| clr_w1c_vld | input | 1 | Write-one-to-clear strobe |
| clr_w1c_mask | input | NUM_CH | Flags to clear |
| clr_chan_vld | input | 1 | Clear-by-number strobe |
| clr_chan | input | CHW | Channel whose flag to clear |
| err_flags | output | NUM_CH | Per-channel error flags |
| err_status | output | 32 | Status word of the last recorded error |

## Verification
The functions that can meet in one cycle are recording several errors at once and clearing against setting. Two datapath ports report in the same cycle with different channels, equal channels, or together with a priority pulse, and each result is judged from the status word and the flag vector. A clear strobe is driven on the same edge as a new error for that channel, and the bench expects the flag to stay set. A bus fault is also offered while a finish is pending, and the bench expects neither an abort pulse nor a flag for it.

// File: rtl/dma_err_pkg.sv
package dma_err_pkg;

    localparam int CHN_W  = 6;
    localparam int STAT_W = 32;

    typedef enum logic [2:0] {
        EK_SRC_ADDR  = 3'd0,
        EK_SRC_OFF   = 3'd1,
        EK_DST_ADDR  = 3'd2,
        EK_DST_OFF   = 3'd3,
        EK_XFER_CFG  = 3'd4,
        EK_SCAT_GATH = 3'd5,
        EK_SRC_BUS   = 3'd6,
        EK_DST_BUS   = 3'd7
    } err_kind_e;

    typedef struct packed {
        logic             vld;
        logic [CHN_W-1:0] chan;
        err_kind_e        kind;
    } err_ev_t;

    typedef struct packed {
        logic             valid;
        logic [14:0]      rsvd;
        logic             grp_prio;
        logic             ch_prio;
        logic [CHN_W-1:0] chan;
        logic [7:0]       kind_flags;
    } err_stat_t;

    // kind 0 maps to the most significant flag bit
    function automatic logic [7:0] kind_flag(err_kind_e k);
        return 8'h80 >> k;
    endfunction

endpackage

// File: rtl/err_abort_seq.sv
module err_abort_seq
    import dma_err_pkg::*;
#(
    parameter int CHW = 6
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           bus_flt_vld,
    input  logic           bus_flt_wr,
    input  logic           bus_flt_last,
    input  logic [CHW-1:0] bus_flt_chan,
    input  logic           phase_done,
    output logic           finish_phase,
    output logic           abort_vld,
    output logic [CHW-1:0] abort_chan,
    output err_ev_t        abort_ev
);

    logic           finish_q;
    logic           pend_wr_q;
    logic [CHW-1:0] pend_chan_q;
    logic           abt_vld_q;
    logic           abt_wr_q;
    logic [CHW-1:0] abt_chan_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            finish_q    <= 1'b0;
            pend_wr_q   <= 1'b0;
            pend_chan_q <= '0;
            abt_vld_q   <= 1'b0;
            abt_wr_q    <= 1'b0;
            abt_chan_q  <= '0;
        end else begin
            abt_vld_q <= 1'b0;
            if (finish_q) begin
                if (phase_done) begin
                    finish_q   <= 1'b0;
                    abt_vld_q  <= 1'b1;
                    abt_wr_q   <= pend_wr_q;
                    abt_chan_q <= pend_chan_q;
                end
            end else if (bus_flt_vld) begin
                if (bus_flt_last) begin
                    finish_q    <= 1'b1;
                    pend_wr_q   <= bus_flt_wr;
                    pend_chan_q <= bus_flt_chan;
                end else begin
                    abt_vld_q  <= 1'b1;
                    abt_wr_q   <= bus_flt_wr;
                    abt_chan_q <= bus_flt_chan;
                end
            end
        end
    end

    assign finish_phase  = finish_q;
    assign abort_vld     = abt_vld_q;
    assign abort_chan    = abt_chan_q;
    assign abort_ev.vld  = abt_vld_q;
    assign abort_ev.chan = CHN_W'(abt_chan_q);
    assign abort_ev.kind = abt_wr_q ? EK_DST_BUS : EK_SRC_BUS;

    assert_mid_fault_abort_R7: assert property (@(posedge clk) disable iff (rst)
        (bus_flt_vld && !bus_flt_last && !finish_q)
        |=> (abort_vld && abort_chan == $past(bus_flt_chan)));

    assert_finish_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (finish_q && !phase_done) |=> (finish_q && !abort_vld));

    assert_finish_release_R8: assert property (@(posedge clk) disable iff (rst)
        (finish_q && phase_done) |=> (!finish_q && abort_vld));

    assert_ignore_pending_R9: assert property (@(posedge clk) disable iff (rst)
        (finish_q && !phase_done && bus_flt_vld) |=> !abort_vld);

endmodule

// File: rtl/err_pick.sv
module err_pick
    import dma_err_pkg::*;
#(
    parameter int NUM_EV = 3
) (
    input  logic                  clk,
    input  logic                  rst,
    input  err_ev_t [NUM_EV-1:0]  ev,
    output err_ev_t               pick
);

    // lowest channel wins; on equal channels the lower index is kept
    always_comb begin
        pick = '0;
        for (int i = 0; i < NUM_EV; i++) begin
            if (ev[i].vld && (!pick.vld || ev[i].chan < pick.chan)) begin
                pick = ev[i];
            end
        end
    end

    for (genvar g = 0; g < NUM_EV; g++) begin : g_chk
        assert_lowest_chan_R4: assert property (@(posedge clk) disable iff (rst)
            ev[g].vld |-> (pick.vld && pick.chan <= ev[g].chan));
    end

endmodule

// File: rtl/err_log.sv
module err_log
    import dma_err_pkg::*;
#(
    parameter int NUM_CH = 64,
    parameter int NUM_EV = 3,
    parameter int CHW    = 6
) (
    input  logic                 clk,
    input  logic                 rst,
    input  err_ev_t [NUM_EV-1:0] ev,
    input  err_ev_t              pick,
    input  logic                 grp_prio_err,
    input  logic                 ch_prio_err,
    input  logic                 clr_w1c_vld,
    input  logic [NUM_CH-1:0]    clr_w1c_mask,
    input  logic                 clr_chan_vld,
    input  logic [CHW-1:0]       clr_chan,
    output logic [NUM_CH-1:0]    err_flags,
    output err_stat_t            status
);

    logic [NUM_CH-1:0] flags_q;
    logic [NUM_CH-1:0] set_mask;
    logic [NUM_CH-1:0] clr_mask;
    logic              gpe_q;
    logic              cpe_q;
    logic [CHN_W-1:0]  chn_q;
    logic [7:0]        typ_q;

    always_comb begin
        set_mask = '0;
        for (int i = 0; i < NUM_EV; i++) begin
            if (ev[i].vld) set_mask[ev[i].chan[CHW-1:0]] = 1'b1;
        end
        clr_mask = clr_w1c_vld ? clr_w1c_mask : '0;
        if (clr_chan_vld) clr_mask[clr_chan] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flags_q <= '0;
            gpe_q   <= 1'b0;
            cpe_q   <= 1'b0;
            chn_q   <= '0;
            typ_q   <= '0;
        end else begin
            flags_q <= (flags_q & ~clr_mask) | set_mask;
            if (pick.vld) begin
                gpe_q <= 1'b0;
                cpe_q <= 1'b0;
                chn_q <= pick.chan;
                typ_q <= kind_flag(pick.kind);
            end else if (grp_prio_err || ch_prio_err) begin
                gpe_q <= grp_prio_err;
                cpe_q <= ch_prio_err;
                typ_q <= '0;
            end
        end
    end

    assign err_flags         = flags_q;
    assign status.valid      = |flags_q;
    assign status.rsvd       = '0;
    assign status.grp_prio   = gpe_q;
    assign status.ch_prio    = cpe_q;
    assign status.chan       = chn_q;
    assign status.kind_flags = typ_q;

    for (genvar g = 0; g < NUM_EV; g++) begin : g_chk
        assert_flag_set_R1: assert property (@(posedge clk) disable iff (rst)
            ev[g].vld |=> flags_q[$past(ev[g].chan[CHW-1:0])]);
    end

    assert_prio_record_R5: assert property (@(posedge clk) disable iff (rst)
        (!pick.vld && (grp_prio_err || ch_prio_err))
        |=> (typ_q == 8'h00 && $stable(chn_q) && $stable(flags_q)));

    assert_clear_chan_R6: assert property (@(posedge clk) disable iff (rst)
        (clr_chan_vld && !set_mask[clr_chan]) |=> !flags_q[$past(clr_chan)]);

    assert_chan_beats_prio_R10: assert property (@(posedge clk) disable iff (rst)
        (pick.vld && (grp_prio_err || ch_prio_err)) |=> (!gpe_q && !cpe_q && $onehot(typ_q)));

endmodule

// File: rtl/dma_err_capture.sv
module dma_err_capture
    import dma_err_pkg::*;
#(
    parameter int NUM_CH  = 64,
    parameter int NUM_SRC = 2,
    localparam int CHW    = $clog2(NUM_CH),
    localparam int NUM_EV = NUM_SRC + 1
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic [NUM_SRC-1:0]            cfg_err_vld,
    input  logic [NUM_SRC-1:0][CHW-1:0]   cfg_err_chan,
    input  logic [NUM_SRC-1:0][2:0]       cfg_err_kind,
    input  logic                          grp_prio_err,
    input  logic                          ch_prio_err,
    input  logic                          bus_flt_vld,
    input  logic                          bus_flt_wr,
    input  logic                          bus_flt_last,
    input  logic [CHW-1:0]                bus_flt_chan,
    input  logic                          phase_done,
    output logic                          finish_phase,
    output logic                          abort_vld,
    output logic [CHW-1:0]                abort_chan,
    input  logic                          clr_w1c_vld,
    input  logic [NUM_CH-1:0]             clr_w1c_mask,
    input  logic                          clr_chan_vld,
    input  logic [CHW-1:0]                clr_chan,
    output logic [NUM_CH-1:0]             err_flags,
    output logic [STAT_W-1:0]             err_status
);

    err_ev_t [NUM_EV-1:0] cand;
    err_ev_t              abort_ev;
    err_ev_t              pick;
    err_stat_t            status;

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
        assign cand[g].vld  = cfg_err_vld[g];
        assign cand[g].chan = CHN_W'(cfg_err_chan[g]);
        assign cand[g].kind = err_kind_e'(cfg_err_kind[g]);
    end
    assign cand[NUM_SRC] = abort_ev;

    err_abort_seq #(.CHW(CHW)) i_seq (
        .clk          (clk),
        .rst          (rst),
        .bus_flt_vld  (bus_flt_vld),
        .bus_flt_wr   (bus_flt_wr),
        .bus_flt_last (bus_flt_last),
        .bus_flt_chan (bus_flt_chan),
        .phase_done   (phase_done),
        .finish_phase (finish_phase),
        .abort_vld    (abort_vld),
        .abort_chan   (abort_chan),
        .abort_ev     (abort_ev)
    );

    err_pick #(.NUM_EV(NUM_EV)) i_pick (
        .clk  (clk),
        .rst  (rst),
        .ev   (cand),
        .pick (pick)
    );

    err_log #(.NUM_CH(NUM_CH), .NUM_EV(NUM_EV), .CHW(CHW)) i_log (
        .clk          (clk),
        .rst          (rst),
        .ev           (cand),
        .pick         (pick),
        .grp_prio_err (grp_prio_err),
        .ch_prio_err  (ch_prio_err),
        .clr_w1c_vld  (clr_w1c_vld),
        .clr_w1c_mask (clr_w1c_mask),
        .clr_chan_vld (clr_chan_vld),
        .clr_chan     (clr_chan),
        .err_flags    (err_flags),
        .status       (status)
    );

    assign err_status = status;

endmodule

// File: tb/test_dma_err_capture.sv
module test_dma_err_capture;

    localparam int CLK_PERIOD = 10;
    localparam int NCH = 64;
    localparam int NV  = 10;

    typedef struct packed {
        logic        v0;
        logic [5:0]  c0;
        logic [2:0]  k0;
        logic        v1;
        logic [5:0]  c1;
        logic [2:0]  k1;
        logic        grp;
        logic        chp;
        logic [31:0] exp_st;
    } vec_t;

    // each vector runs after all flags are cleared
    localparam vec_t VECS [NV] = '{
        '{1'b1, 6'd5,  3'd0, 1'b0, 6'd0,  3'd0, 1'b0, 1'b0, 32'h8000_0580}, // R1 R3
        '{1'b0, 6'd0,  3'd0, 1'b1, 6'd12, 3'd4, 1'b0, 1'b0, 32'h8000_0C08}, // R1 R3
        '{1'b1, 6'd40, 3'd1, 1'b1, 6'd3,  3'd5, 1'b0, 1'b0, 32'h8000_0304}, // R4 lowest
        '{1'b1, 6'd9,  3'd2, 1'b1, 6'd9,  3'd3, 1'b0, 1'b0, 32'h8000_0920}, // R4 tie
        '{1'b0, 6'd0,  3'd0, 1'b0, 6'd0,  3'd0, 1'b1, 1'b0, 32'h0000_8900}, // R5 group
        '{1'b0, 6'd0,  3'd0, 1'b0, 6'd0,  3'd0, 1'b0, 1'b1, 32'h0000_4900}, // R5 channel
        '{1'b1, 6'd63, 3'd3, 1'b0, 6'd0,  3'd0, 1'b1, 1'b1, 32'h8000_3F10}, // R10
        '{1'b0, 6'd0,  3'd0, 1'b0, 6'd0,  3'd0, 1'b1, 1'b1, 32'h0000_FF00}, // R5 both
        '{1'b0, 6'd0,  3'd0, 1'b1, 6'd0,  3'd2, 1'b0, 1'b0, 32'h8000_0020}, // R3 chan 0
        '{1'b1, 6'd62, 3'd5, 1'b1, 6'd61, 3'd0, 1'b0, 1'b0, 32'h8000_3D80}  // R4
    };

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [1:0]       cfg_err_vld = '0;
    logic [1:0][5:0]  cfg_err_chan = '0;
    logic [1:0][2:0]  cfg_err_kind = '0;
    logic             grp_prio_err = 1'b0;
    logic             ch_prio_err = 1'b0;
    logic             bus_flt_vld = 1'b0;
    logic             bus_flt_wr = 1'b0;
    logic             bus_flt_last = 1'b0;
    logic [5:0]       bus_flt_chan = '0;
    logic             phase_done = 1'b0;
    logic             finish_phase;
    logic             abort_vld;
    logic [5:0]       abort_chan;
    logic             clr_w1c_vld = 1'b0;
    logic [NCH-1:0]   clr_w1c_mask = '0;
    logic             clr_chan_vld = 1'b0;
    logic [5:0]       clr_chan = '0;
    logic [NCH-1:0]   err_flags;
    logic [31:0]      err_status;

    int n_chk  = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dma_err_capture #(.NUM_CH(NCH), .NUM_SRC(2)) i_dma_err_capture (
        .clk, .rst, .cfg_err_vld, .cfg_err_chan, .cfg_err_kind,
        .grp_prio_err, .ch_prio_err, .bus_flt_vld, .bus_flt_wr,
        .bus_flt_last, .bus_flt_chan, .phase_done, .finish_phase,
        .abort_vld, .abort_chan, .clr_w1c_vld, .clr_w1c_mask,
        .clr_chan_vld, .clr_chan, .err_flags, .err_status
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic clear_all();
        clr_w1c_vld  = 1'b1;
        clr_w1c_mask = '1;
        tick();
        clr_w1c_vld  = 1'b0;
        clr_w1c_mask = '0;
    endtask

    task automatic bus_fault(input logic wr, input logic last, input logic [5:0] ch);
        bus_flt_vld  = 1'b1;
        bus_flt_wr   = wr;
        bus_flt_last = last;
        bus_flt_chan = ch;
        tick();
        bus_flt_vld  = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        n_fail++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [63:0] ef;
        repeat (3) tick();
        rst = 1'b0;
        tick();
        chk("reset flags", err_flags, 64'd0);
        chk("reset status", {32'd0, err_status}, 64'd0);
        chk("reset finish/abort", {62'd0, finish_phase, abort_vld}, 64'd0);

        // table walk: R1 R3 R4 R5 R10
        for (int i = 0; i < NV; i++) begin
            clear_all();
            cfg_err_vld  = {VECS[i].v1, VECS[i].v0};
            cfg_err_chan = {VECS[i].c1, VECS[i].c0};
            cfg_err_kind = {VECS[i].k1, VECS[i].k0};
            grp_prio_err = VECS[i].grp;
            ch_prio_err  = VECS[i].chp;
            tick();
            cfg_err_vld  = '0;
            grp_prio_err = 1'b0;
            ch_prio_err  = 1'b0;
            ef = 64'd0;
            if (VECS[i].v0) ef |= 64'd1 << VECS[i].c0;
            if (VECS[i].v1) ef |= 64'd1 << VECS[i].c1;
            chk("R1 R3 R4 R5 R10 vector status", {32'd0, err_status}, {32'd0, VECS[i].exp_st});
            chk("R1 R4 vector flags", err_flags, ef);
        end

        // R6 / R2 clearing
        clear_all();
        cfg_err_vld  = 2'b11;
        cfg_err_chan = {6'd20, 6'd7};
        cfg_err_kind = {3'd1, 3'd0};
        tick();
        cfg_err_vld  = '0;
        clr_w1c_vld  = 1'b1;
        clr_w1c_mask = 64'd1 << 7;
        tick();
        clr_w1c_vld  = 1'b0;
        chk("R6 w1c clears flag 7 only", err_flags, 64'd1 << 20);
        chk("R2 valid with one flag", {63'd0, err_status[31]}, 64'd1);
        clr_chan_vld = 1'b1;
        clr_chan     = 6'd20;
        tick();
        clr_chan_vld = 1'b0;
        chk("R6 clear by number", err_flags, 64'd0);
        chk("R2 valid drops, fields kept", {32'd0, err_status}, {32'd0, 32'h0000_0780});

        // R6 set wins over clear
        cfg_err_vld  = 2'b01;
        cfg_err_chan = {6'd0, 6'd7};
        cfg_err_kind = {3'd0, 3'd2};
        clr_chan_vld = 1'b1;
        clr_chan     = 6'd7;
        tick();
        cfg_err_vld  = '0;
        clr_chan_vld = 1'b0;
        chk("R6 set wins over clear", err_flags, 64'd1 << 7);

        // R11 re-error after clear
        clear_all();
        chk("R11 cleared before repeat", err_flags, 64'd0);
        cfg_err_vld  = 2'b01;
        cfg_err_kind = {3'd0, 3'd1};
        tick();
        cfg_err_vld  = '0;
        chk("R11 repeat error re-sets flag", err_flags, 64'd1 << 7);
        chk("R11 repeat error status", {32'd0, err_status}, {32'd0, 32'h8000_0740});

        // R7 mid-phase read fault
        clear_all();
        bus_fault(1'b0, 1'b0, 6'd11);
        chk("R7 abort pulse read", {57'd0, finish_phase, abort_vld, abort_chan}, {57'd0, 1'b0, 1'b1, 6'd11});
        tick();
        chk("R7 abort one cycle", {63'd0, abort_vld}, 64'd0);
        chk("R7 source bus logged", {32'd0, err_status}, {32'd0, 32'h8000_0B02});

        // R7 mid-phase write fault
        clear_all();
        bus_fault(1'b1, 1'b0, 6'd2);
        chk("R7 abort pulse write", {57'd0, finish_phase, abort_vld, abort_chan}, {57'd0, 1'b0, 1'b1, 6'd2});
        tick();
        chk("R7 dest bus logged", {32'd0, err_status}, {32'd0, 32'h8000_0201});

        // R8 last-beat read fault, R9 fault during finish
        clear_all();
        bus_fault(1'b0, 1'b1, 6'd30);
        chk("R8 finish raised, no abort", {62'd0, finish_phase, abort_vld}, {62'd0, 2'b10});
        bus_fault(1'b1, 1'b0, 6'd4);
        chk("R9 fault during finish ignored", {62'd0, finish_phase, abort_vld}, {62'd0, 2'b10});
        tick();
        chk("R8 R9 no flag while pending", err_flags, 64'd0);
        phase_done = 1'b1;
        tick();
        phase_done = 1'b0;
        chk("R8 abort after phase_done", {57'd0, finish_phase, abort_vld, abort_chan}, {57'd0, 1'b0, 1'b1, 6'd30});
        tick();
        chk("R8 logged source bus", {32'd0, err_status}, {32'd0, 32'h8000_1E02});
        chk("R8 R9 only faulting flag", err_flags, 64'd1 << 30);

        // R8 last-beat write fault
        clear_all();
        bus_fault(1'b1, 1'b1, 6'd33);
        tick();
        chk("R8 still pending", {62'd0, finish_phase, abort_vld}, {62'd0, 2'b10});
        phase_done = 1'b1;
        tick();
        phase_done = 1'b0;
        chk("R8 write abort", {57'd0, finish_phase, abort_vld, abort_chan}, {57'd0, 1'b0, 1'b1, 6'd33});
        tick();
        chk("R8 logged dest bus", {32'd0, err_status}, {32'd0, 32'h8000_2101});

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule